// File: doc/BRIEF.md
# Secondary-Bus Parity/ECC Error Handler

This block sorts and reports the parity and ECC errors that the downstream (secondary) side of a bus bridge sees. The bus protocol engine and the ECC decoder stay outside. Each transaction reaches the block as a set of qualified indications: the bus mode, whether an error was seen, its severity, whether it hit the address/attribute phase or a data phase, the transaction kind, and the external parity-error signal returned by a target on data the bridge drove.

From these indications the block sets sticky status bits. In ECC mode it also captures the address, attribute and error class of the first logged error. It emits one-cycle pulses that tell the protocol engine to let a corrected transfer go on, to drop a transaction and terminate it with a target abort, or to tag an upstream write completion as a data-error response. A latched address/attribute error is routed to a system-flood output and to fatal and nonfatal interrupt outputs. Each route has its own control.

Software clears the status through a write-1-to-clear port. A clear-log control turns the address/attribute error flag from a sticky bit into a single-cycle pulse.

Top module: `sbe_err_handler`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next state has `stat`, `cap_addr`, `cap_attr`, `cap_multi`, `cap_addr_phase` and every pulse and routing output at zero.
- R2: A valid transaction with `txn_kind` = 0 (non-posted write driven by the bridge) and `ext_perr` high sets `stat[0]` (master data error) only if `cfg_uncorr_resp_en` is high. The same condition with `txn_kind` 1 (immediate read), 2 (split completion) or 3 (inbound) changes no status bit and no output.
- R3: For a valid kind-0 transaction with `ext_perr` high, `resp_err` pulses for one cycle only if `cfg_perr_resp_en` is high and `cfg_up_err_dis` is low.
- R4: An error is correctable only when `bus_ecc_mode` = 1, `err_multi` = 0 and `cfg_no_sbc` = 0. A correctable error pulses `corr_pulse` and sets `stat[1]`, and causes no drop and no uncorrectable status.
- R5: Every error that R4 does not make correctable is uncorrectable and sets `stat[2]`. This covers every error in parity mode (`bus_ecc_mode` = 0), and multi-bit or correction-disabled errors in ECC mode.
- R6: In ECC mode every error, correctable or not, is logged. If `stat[4]` is clear, it captures `txn_addr`, `txn_attr`, `err_multi` and `err_addr_phase` and sets `stat[4]`. While `stat[4]` stays set, later errors do not overwrite the capture. Parity-mode errors never log.
- R7: An uncorrectable error with `err_addr_phase` = 1 sets `stat[3]` and pulses `drop_abort`. A data-phase error never pulses `drop_abort`.
- R8: With `cfg_clr_log` high, `stat[3]` is high for exactly one cycle after it is set. With `cfg_clr_log` low, it stays set until cleared.
- R9: `flood` = `stat[3]` & `cfg_uncorr_resp_en` & ~`cfg_flood_dis`. `irq_fatal` and `irq_nonfatal` equal `stat[3]` & `cfg_uncorr_resp_en` gated by `cfg_fatal_en` and `cfg_nonfatal_en` respectively. All three follow `stat[3]` in the same cycle.
- R10: A cycle with `clr_we` high clears each `stat` bit whose `clr_mask` bit is 1. A set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txn_valid | input | 1 | Qualifies all transaction inputs this cycle |
| txn_kind | input | 2 | 0 non-posted write out, 1 immediate read, 2 split completion, 3 inbound |
| bus_ecc_mode | input | 1 | 1 ECC mode, 0 parity mode |
| err_detect | input | 1 | An error was found on this transaction |
| err_multi | input | 1 | Error is multi-bit |
| err_addr_phase | input | 1 | Error hit the address/attribute phase |
| ext_perr | input | 1 | External parity-error signal on data the bridge drove |
| txn_addr | input | ADDR_W | Transaction address |
| txn_attr | input | ATTR_W | Transaction attribute |
| cfg_uncorr_resp_en | input | 1 | Uncorrectable-error response enable |
| cfg_perr_resp_en | input | 1 | Parity-error response enable |
| cfg_up_err_dis | input | 1 | Global disable of upstream error tagging |
| cfg_no_sbc | input | 1 | Disable single-bit correction |
| cfg_clr_log | input | 1 | Address error flag pulses instead of latching |
| cfg_flood_dis | input | 1 | Disable flood routing |
| cfg_fatal_en | input | 1 | Route to fatal interrupt |
| cfg_nonfatal_en | input | 1 | Route to nonfatal interrupt |
| clr_we | input | 1 | Write-1-to-clear strobe |
| clr_mask | input | 5 | Status bits to clear |
| stat | output | 5 | [0] master data err, [1] corrected, [2] uncorrectable, [3] addr/attr err, [4] ECC log valid |
| cap_addr | output | ADDR_W | Captured address |
| cap_attr | output | ATTR_W | Captured attribute |
| cap_multi | output | 1 | Captured severity |
| cap_addr_phase | output | 1 | Captured phase |
| corr_pulse | output | 1 | Correction applied, transaction proceeds |
| drop_abort | output | 1 | Drop transaction and target-abort it |
| resp_err | output | 1 | Tag upstream completion as data error |
| flood | output | 1 | System flood request |
| irq_fatal | output | 1 | Fatal interrupt |
| irq_nonfatal | output | 1 | Nonfatal interrupt |

## Verification
Each status bit, capture field and pulse comes from one register. A transaction driven before rising edge N therefore shows its result between edges N and N+1, and the pulses are gone after edge N+1. The routing outputs follow `stat[3]` in that same window. The bench drives inputs on falling edges and samples on the next falling edge, which sits in the middle of that window. It checks clear-log decay and first-error hold one falling edge later still. A full sweep over mode, severity, phase, kind, external error and the enables is followed by directed sequences for the pulse, hold and clear cases.

// File: rtl/sbe_pkg.sv
// Package: shared constants and the per-transaction event record for the
// secondary-bus error handler. Assumes a five-bit status vector.
package sbe_pkg;
    localparam int STAT_W   = 5;
    localparam int IDX_MDE  = 0;   // master data error
    localparam int IDX_CORR = 1;   // ECC corrected
    localparam int IDX_UNC  = 2;   // detected uncorrectable
    localparam int IDX_ADDR = 3;   // address/attribute phase error
    localparam int IDX_LOG  = 4;   // ECC log holds a capture

    localparam logic [1:0] KIND_NPW   = 2'd0;
    localparam logic [1:0] KIND_IRD   = 2'd1;
    localparam logic [1:0] KIND_SPLIT = 2'd2;
    localparam logic [1:0] KIND_IN    = 2'd3;

    typedef struct packed {
        logic corr;      // correctable error, corrected
        logic uncorr;    // uncorrectable error
        logic addr_err;  // uncorrectable in address/attribute phase
        logic mde;       // master data error condition
        logic resp_err;  // tag upstream completion
        logic log_ev;    // ECC-mode error to be logged
    } err_event_t;
endpackage

// File: rtl/sbe_classify.sv
// Module: sbe_classify
// Purely combinational. Turns one cycle of qualified transaction inputs into
// an event record. Assumes the inputs are meaningful only while valid is high.
module sbe_classify
    import sbe_pkg::*;
(
    input  logic       valid,
    input  logic [1:0] kind,
    input  logic       ecc_mode,
    input  logic       detect,
    input  logic       multi,
    input  logic       addr_phase,
    input  logic       ext_perr,
    input  logic       uncorr_en,
    input  logic       perr_en,
    input  logic       up_dis,
    input  logic       no_sbc,
    output err_event_t ev
);
    logic seen;
    logic fixable;
    logic npw_perr;

    // Decide correctability and build the event record.
    always_comb begin
        seen     = valid & detect;
        fixable  = ecc_mode & ~multi & ~no_sbc;
        npw_perr = valid & ext_perr & (kind == KIND_NPW);
        ev.corr     = seen & fixable;
        ev.uncorr   = seen & ~fixable;
        ev.addr_err = seen & ~fixable & addr_phase;
        ev.mde      = npw_perr & uncorr_en;
        ev.resp_err = npw_perr & perr_en & ~up_dis;
        ev.log_ev   = seen & ecc_mode;
    end
endmodule

// File: rtl/sbe_status.sv
// Module: sbe_status
// Sticky status bits with write-1-to-clear, the first-error capture for
// ECC mode, and the one-cycle action pulses. A set beats a clear in the same
// cycle. Assumes the event record comes from sbe_classify.
module sbe_status
    import sbe_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int ATTR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  err_event_t        ev,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ATTR_W-1:0] attr,
    input  logic              multi,
    input  logic              addr_phase,
    input  logic              clr_log,
    input  logic              clr_we,
    input  logic [STAT_W-1:0] clr_mask,
    output logic [STAT_W-1:0] stat,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [ATTR_W-1:0] cap_attr,
    output logic              cap_multi,
    output logic              cap_addr_phase,
    output logic              corr_pulse,
    output logic              drop_abort,
    output logic              resp_err
);
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] auto_clr;
    logic [STAT_W-1:0] stat_q;
    logic              take_capture;

    // Map events onto status bits; only the address flag self-clears.
    always_comb begin
        set_vec           = '0;
        set_vec[IDX_MDE]  = ev.mde;
        set_vec[IDX_CORR] = ev.corr;
        set_vec[IDX_UNC]  = ev.uncorr;
        set_vec[IDX_ADDR] = ev.addr_err;
        set_vec[IDX_LOG]  = ev.log_ev;
        auto_clr           = '0;
        auto_clr[IDX_ADDR] = clr_log;
        take_capture = ev.log_ev &
                       (~stat_q[IDX_LOG] | (clr_we & clr_mask[IDX_LOG]));
    end

    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        // One sticky bit: set wins, then auto clear, then software clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stat_q[i] <= 1'b0;
            else if (set_vec[i])
                stat_q[i] <= 1'b1;
            else if (auto_clr[i])
                stat_q[i] <= 1'b0;
            else if (clr_we && clr_mask[i])
                stat_q[i] <= 1'b0;
        end
    end

    // Capture the first ECC-mode error until the log bit is cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr       <= '0;
            cap_attr       <= '0;
            cap_multi      <= 1'b0;
            cap_addr_phase <= 1'b0;
        end else if (take_capture) begin
            cap_addr       <= addr;
            cap_attr       <= attr;
            cap_multi      <= multi;
            cap_addr_phase <= addr_phase;
        end
    end

    // Register the one-cycle action pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            corr_pulse <= 1'b0;
            drop_abort <= 1'b0;
            resp_err   <= 1'b0;
        end else begin
            corr_pulse <= ev.corr;
            drop_abort <= ev.addr_err;
            resp_err   <= ev.resp_err;
        end
    end

    assign stat = stat_q;

    // R4: a correction pulse always comes with the corrected status bit.
    assert_corr_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        corr_pulse |-> stat_q[IDX_CORR]);

    // R7: a drop/abort pulse always comes with the address error flag.
    assert_drop_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        drop_abort |-> stat_q[IDX_ADDR]);

    // R4, R7: a transaction is never both corrected and dropped.
    assert_corr_drop_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(corr_pulse && drop_abort));

    // R8: in clear-log mode the flag lasts one cycle unless set again.
    assert_clrlog_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_log && stat_q[IDX_ADDR]) |=> (!stat_q[IDX_ADDR] || drop_abort));

    // R6: the capture holds while the log bit stays set and is not cleared.
    assert_capture_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[IDX_LOG] && !(clr_we && clr_mask[IDX_LOG]))
            |=> ($stable(cap_addr) && $stable(cap_attr)));
endmodule

// File: rtl/sbe_route.sv
// Module: sbe_route
// Combinational routing of the latched address/attribute error to the flood
// and interrupt outputs. Assumes addr_flag is already registered.
module sbe_route (
    input  logic addr_flag,
    input  logic uncorr_en,
    input  logic flood_dis,
    input  logic fatal_en,
    input  logic nonfatal_en,
    output logic flood,
    output logic irq_fatal,
    output logic irq_nonfatal
);
    logic armed;

    // Gate the flag with the response enable, then per route.
    always_comb begin
        armed        = addr_flag & uncorr_en;
        flood        = armed & ~flood_dis;
        irq_fatal    = armed & fatal_en;
        irq_nonfatal = armed & nonfatal_en;
    end
endmodule

// File: rtl/sbe_err_handler.sv
// Module: sbe_err_handler (top)
// Secondary-bus parity/ECC error handler: classifies each qualified
// transaction, keeps sticky status and capture, emits action pulses and
// routes address/attribute errors. All results are registered one edge after
// the sampling edge; routing follows the registered flag combinationally.
module sbe_err_handler
    import sbe_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int ATTR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_valid,
    input  logic [1:0]        txn_kind,
    input  logic              bus_ecc_mode,
    input  logic              err_detect,
    input  logic              err_multi,
    input  logic              err_addr_phase,
    input  logic              ext_perr,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic [ATTR_W-1:0] txn_attr,
    input  logic              cfg_uncorr_resp_en,
    input  logic              cfg_perr_resp_en,
    input  logic              cfg_up_err_dis,
    input  logic              cfg_no_sbc,
    input  logic              cfg_clr_log,
    input  logic              cfg_flood_dis,
    input  logic              cfg_fatal_en,
    input  logic              cfg_nonfatal_en,
    input  logic              clr_we,
    input  logic [4:0]        clr_mask,
    output logic [4:0]        stat,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [ATTR_W-1:0] cap_attr,
    output logic              cap_multi,
    output logic              cap_addr_phase,
    output logic              corr_pulse,
    output logic              drop_abort,
    output logic              resp_err,
    output logic              flood,
    output logic              irq_fatal,
    output logic              irq_nonfatal
);
    err_event_t ev;

    sbe_classify u_classify (
        .valid      (txn_valid),
        .kind       (txn_kind),
        .ecc_mode   (bus_ecc_mode),
        .detect     (err_detect),
        .multi      (err_multi),
        .addr_phase (err_addr_phase),
        .ext_perr   (ext_perr),
        .uncorr_en  (cfg_uncorr_resp_en),
        .perr_en    (cfg_perr_resp_en),
        .up_dis     (cfg_up_err_dis),
        .no_sbc     (cfg_no_sbc),
        .ev         (ev)
    );

    sbe_status #(.ADDR_W(ADDR_W), .ATTR_W(ATTR_W)) u_status (
        .clk            (clk),
        .rst_n          (rst_n),
        .ev             (ev),
        .addr           (txn_addr),
        .attr           (txn_attr),
        .multi          (err_multi),
        .addr_phase     (err_addr_phase),
        .clr_log        (cfg_clr_log),
        .clr_we         (clr_we),
        .clr_mask       (clr_mask),
        .stat           (stat),
        .cap_addr       (cap_addr),
        .cap_attr       (cap_attr),
        .cap_multi      (cap_multi),
        .cap_addr_phase (cap_addr_phase),
        .corr_pulse     (corr_pulse),
        .drop_abort     (drop_abort),
        .resp_err       (resp_err)
    );

    sbe_route u_route (
        .addr_flag    (stat[IDX_ADDR]),
        .uncorr_en    (cfg_uncorr_resp_en),
        .flood_dis    (cfg_flood_dis),
        .fatal_en     (cfg_fatal_en),
        .nonfatal_en  (cfg_nonfatal_en),
        .flood        (flood),
        .irq_fatal    (irq_fatal),
        .irq_nonfatal (irq_nonfatal)
    );

    // R9: no routed output without the latched address/attribute flag.
    assert_route_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flood || irq_fatal || irq_nonfatal) |-> stat[IDX_ADDR]);
endmodule

// File: tb/sbe_err_handler_tb.sv
`timescale 1ns/1ps
module sbe_err_handler_tb_top;
    localparam int AW = 16;
    localparam int TW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txn_valid = 0, bus_ecc_mode = 0, err_detect = 0, err_multi = 0;
    logic err_addr_phase = 0, ext_perr = 0;
    logic [1:0] txn_kind = '0;
    logic [AW-1:0] txn_addr = '0;
    logic [TW-1:0] txn_attr = '0;
    logic cfg_uncorr_resp_en = 0, cfg_perr_resp_en = 0, cfg_up_err_dis = 0;
    logic cfg_no_sbc = 0, cfg_clr_log = 0, cfg_flood_dis = 0;
    logic cfg_fatal_en = 0, cfg_nonfatal_en = 0, clr_we = 0;
    logic [4:0] clr_mask = '0;
    logic [4:0] stat;
    logic [AW-1:0] cap_addr;
    logic [TW-1:0] cap_attr;
    logic cap_multi, cap_addr_phase, corr_pulse, drop_abort, resp_err;
    logic flood, irq_fatal, irq_nonfatal;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sbe_err_handler #(.ADDR_W(AW), .ATTR_W(TW)) dut_i (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one qualified transaction for one edge, then idle.
    task automatic txn(input logic ecc, input logic det, input logic mul,
                       input logic aph, input logic [1:0] knd, input logic pe,
                       input logic [AW-1:0] a, input logic [TW-1:0] t);
        bus_ecc_mode = ecc; err_detect = det; err_multi = mul;
        err_addr_phase = aph; txn_kind = knd; ext_perr = pe;
        txn_addr = a; txn_attr = t; txn_valid = 1'b1;
        @(negedge clk);
        txn_valid = 1'b0; err_detect = 1'b0; ext_perr = 1'b0;
    endtask

    task automatic clear_all();
        clr_we = 1'b1; clr_mask = 5'h1F;
        @(negedge clk);
        clr_we = 1'b0; clr_mask = '0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 stat", 32'(stat), 0);
        chk("R1 pulses", 32'({corr_pulse, drop_abort, resp_err}), 0);
        chk("R1 capture", 32'(cap_addr) | 32'(cap_attr), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Full sweep over mode, severity, phase, kind, perr and enables.
        for (int v = 0; v < 2048; v++) begin
            logic ecc, aph, mul, nsb, det, pe, uen, pen, upd;
            logic [1:0] knd;
            logic e_corr, e_unc, e_drop, e_mde, e_resp, e_log, e_arm;
            logic [AW-1:0] a;
            logic [TW-1:0] t;
            ecc = v[0]; aph = v[1]; mul = v[2]; nsb = v[3]; det = v[4];
            knd = v[6:5]; pe = v[7]; uen = v[8]; pen = v[9]; upd = v[10];
            a = AW'(v * 37 + 5);
            t = TW'(v) ^ 8'h5A;
            cfg_no_sbc = nsb; cfg_uncorr_resp_en = uen; cfg_perr_resp_en = pen;
            cfg_up_err_dis = upd; cfg_flood_dis = v[0] ^ v[3];
            cfg_fatal_en = v[1] ^ v[2]; cfg_nonfatal_en = v[4] ^ v[5];
            e_corr = det & ecc & ~mul & ~nsb;
            e_unc  = det & ~e_corr;
            e_drop = e_unc & aph;
            e_mde  = pe & (knd == 2'd0) & uen;
            e_resp = pe & (knd == 2'd0) & pen & ~upd;
            e_log  = det & ecc;
            e_arm  = e_drop & uen;
            txn(ecc, det, mul, aph, knd, pe, a, t);
            chk("R2 master data err", 32'(stat[0]), 32'(e_mde));
            chk("R3 resp tag", 32'(resp_err), 32'(e_resp));
            chk("R4 corrected", 32'({stat[1], corr_pulse}), 32'({e_corr, e_corr}));
            chk("R5 uncorrectable", 32'(stat[2]), 32'(e_unc));
            chk("R6 log valid", 32'(stat[4]), 32'(e_log));
            if (e_log) begin
                chk("R6 cap addr", 32'(cap_addr), 32'(a));
                chk("R6 cap attr/class", 32'({cap_attr, cap_multi, cap_addr_phase}),
                    32'({t, mul, aph}));
            end
            chk("R7 addr flag/drop", 32'({stat[3], drop_abort}), 32'({e_drop, e_drop}));
            chk("R9 routing", 32'({flood, irq_fatal, irq_nonfatal}),
                32'({e_arm & ~cfg_flood_dis, e_arm & cfg_fatal_en, e_arm & cfg_nonfatal_en}));
            clear_all();
            chk("R10 cleared", 32'(stat), 0);
            chk("R3 pulse one cycle", 32'({corr_pulse, drop_abort, resp_err}), 0);
        end

        // R8: clear-log turns the address flag into a one-cycle pulse.
        cfg_uncorr_resp_en = 1; cfg_flood_dis = 0; cfg_fatal_en = 1; cfg_nonfatal_en = 0;
        cfg_clr_log = 1;
        txn(1'b0, 1'b1, 1'b0, 1'b1, 2'd3, 1'b0, 16'h1234, 8'h11);
        chk("R8 pulse high", 32'({stat[3], flood, irq_fatal}), 32'h7);
        @(negedge clk);
        chk("R8 pulse gone", 32'({stat[3], flood}), 0);
        chk("R8 uncorr stays", 32'(stat[2]), 1);
        cfg_clr_log = 0;
        clear_all();
        txn(1'b0, 1'b1, 1'b0, 1'b1, 2'd3, 1'b0, 16'h1234, 8'h11);
        repeat (3) @(negedge clk);
        chk("R8 latched", 32'({stat[3], irq_fatal}), 32'h3);
        clr_we = 1; clr_mask = 5'b01000;
        @(negedge clk);
        clr_we = 0; clr_mask = '0;
        chk("R10 mask clear", 32'(stat), 32'b00100);
        clear_all();

        // R6: first capture held; clearing the log bit reopens it.
        txn(1'b1, 1'b1, 1'b1, 1'b0, 2'd3, 1'b0, 16'hAAAA, 8'h01);
        txn(1'b1, 1'b1, 1'b0, 1'b1, 2'd3, 1'b0, 16'hBBBB, 8'h02);
        chk("R6 first held", 32'({cap_addr, cap_attr}), 32'h00AAAA01);
        txn(1'b0, 1'b1, 1'b1, 1'b0, 2'd3, 1'b0, 16'hCCCC, 8'h03);
        chk("R6 parity no log", 32'(cap_addr), 32'hAAAA);
        clr_we = 1; clr_mask = 5'b10000;
        @(negedge clk);
        clr_we = 0; clr_mask = '0;
        chk("R6 log cleared", 32'(stat[4]), 0);
        txn(1'b0, 1'b1, 1'b1, 1'b0, 2'd3, 1'b0, 16'hDDDD, 8'h04);
        chk("R6 parity keeps log empty", 32'(stat[4]), 0);
        txn(1'b1, 1'b1, 1'b0, 1'b0, 2'd3, 1'b0, 16'hEEEE, 8'h05);
        chk("R6 recapture", 32'({stat[4], cap_addr}), 32'h1EEEE);

        // R10: set wins over a same-cycle clear.
        clr_we = 1; clr_mask = 5'h1F;
        txn(1'b1, 1'b1, 1'b1, 1'b0, 2'd3, 1'b0, 16'h7777, 8'h06);
        clr_we = 0; clr_mask = '0;
        chk("R10 set beats clear", 32'({stat, cap_addr}), 32'h147777);

        // R1: reset again clears everything.
        rst_n = 0;
        @(negedge clk);
        chk("R1 reset clears", 32'({stat, cap_addr}), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule